// File: doc/BRIEF.md
# Display Line Coherency Tracker

This block keeps two flags for every line of a display frame. The dirty flag records that something wrote the line after it was last compressed. The valid flag records that a good compressed copy of the line exists. The display fetch engine asks the block for a line number. The block answers whether that line should be read from the compressed line store or from the uncompressed frame buffer.

The tracker watches the system's memory write requests. A write that lands inside the programmed frame region marks the matching line dirty. A line compressor reports the outcome for each line it processes. Only a successful outcome marks the line valid, and a failed one changes nothing. An optional static-frame mode alternates frames. In every second frame the dirty flags are ignored, so the display may show a compressed image that is one frame old. Software reads the flags through a small register port and is the only agent that clears them.

Top module: `line_coherency_tracker`

## Requirements
- R1: After synchronous reset every dirty and valid flag is 0, `static_phase` is 0, and `fr_valid`, `fr_from_cmp`, `sw_rd_ack`, `sw_rd_dirty` and `sw_rd_valid` are 0.
- R2: A write request with `snp_valid`=1 and an address A where `region_base` <= A < `region_base` + NUM_LINES*2^`pitch_shift` sets the dirty flag of line (A - `region_base`) >> `pitch_shift` at the next clock edge. The valid flag of that line is left unchanged.
- R3: A write request below `region_base`, a write at or above the end of the region, and any address presented while `snp_valid`=0 change no flag.
- R4: A compressor result with `cmp_valid`=1 and `cmp_ok`=1 sets the valid flag of `cmp_line`. A result with `cmp_ok`=0 changes neither flag of that line.
- R5: If a snooped write and a successful compressor result hit the same line in the same cycle, that line ends with dirty=1 and valid=0. If they hit different lines, both updates take effect.
- R6: A fetch query (`fq_valid`=1, `fq_line`) yields `fr_valid`=1 one cycle later. Outside a static frame, `fr_from_cmp` is 1 (compressed store) exactly when the line is valid and not dirty. Otherwise it is 0 (frame buffer).
- R7: While `static_phase`=1, `fr_from_cmp` equals the line's valid flag, whatever its dirty flag.
- R8: While `static_en`=1, `static_phase` inverts at each clock edge where `sof`=1 and holds otherwise. At an edge where `static_en`=0 it becomes 0.
- R9: A software write (`sw_en`=1, `sw_we`=1) clears the dirty flag of `sw_line` when `sw_clr_dirty`=1 and its valid flag when `sw_clr_valid`=1. No hardware event ever clears a dirty flag.
- R10: A software read (`sw_en`=1, `sw_we`=0) returns the line's flags one cycle later on `sw_rd_dirty` and `sw_rd_valid`, with `sw_rd_ack`=1.
- R11: When a hardware set and a software clear of the same flag of the same line fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_base | input | ADDR_W | First byte address of the monitored frame region |
| pitch_shift | input | SHW | Line pitch as log2 of bytes per line |
| static_en | input | 1 | Enables alternating static frames |
| sof | input | 1 | Start-of-frame pulse |
| snp_valid | input | 1 | Snooped write request present |
| snp_addr | input | ADDR_W | Snooped write address |
| cmp_valid | input | 1 | Compressor result present |
| cmp_line | input | IDX_W | Line the result belongs to |
| cmp_ok | input | 1 | Compression succeeded |
| fq_valid | input | 1 | Fetch source query |
| fq_line | input | IDX_W | Line being fetched |
| sw_en | input | 1 | Software access strobe |
| sw_we | input | 1 | 1 = clear access, 0 = read access |
| sw_line | input | IDX_W | Line addressed by software |
| sw_clr_dirty | input | 1 | Clear the dirty flag on write |
| sw_clr_valid | input | 1 | Clear the valid flag on write |
| fr_valid | output | 1 | Fetch answer present |
| fr_from_cmp | output | 1 | 1 = read compressed store, 0 = read frame buffer |
| sw_rd_ack | output | 1 | Software read data present |
| sw_rd_dirty | output | 1 | Dirty flag read back |
| sw_rd_valid | output | 1 | Valid flag read back |
| static_phase | output | 1 | 1 while the current frame is a static frame |

## Verification
A flag stored in the wrong state shows up at the ports on the next fetch query or software read of that line, one cycle after the query. A stale valid flag sends the display to an outdated compressed line. A lost dirty flag does the same in normal frames. A wrongly decoded snoop address marks a neighbouring line dirty or misses the hit, and a read of both lines exposes this within two cycles. A phase register that drifts from the frame count shows up as a wrong fetch source in the first frame after the drift.

// File: rtl/lct_pkg.sv
package lct_pkg;

  // Per-line update requests gathered in one cycle
  typedef struct packed {
    logic set_dirty;
    logic set_valid;
    logic clr_dirty;
    logic clr_valid;
  } line_upd_t;

endpackage

// File: rtl/lct_snoop_map.sv
module lct_snoop_map #(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int SHW       = $clog2(ADDR_W)
) (
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [SHW-1:0]    pitch_shift,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] LINES_A = ADDR_W'(NUM_LINES);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] line_no;

  always_comb begin
    offset  = snp_addr - region_base;
    line_no = offset >> pitch_shift;
    hit     = snp_valid && (snp_addr >= region_base) && (line_no < LINES_A);
    idx     = line_no[IDX_W-1:0];
  end

endmodule

// File: rtl/lct_bit_store.sv
module lct_bit_store
  import lct_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snp_hit,
  input  logic [IDX_W-1:0]     snp_idx,
  input  logic                 cmp_set,
  input  logic [IDX_W-1:0]     cmp_idx,
  input  logic                 sw_clr_d,
  input  logic                 sw_clr_v,
  input  logic [IDX_W-1:0]     sw_idx,
  output logic [NUM_LINES-1:0] dirty_q,
  output logic [NUM_LINES-1:0] valid_q
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_upd_t upd;

    always_comb begin
      upd.set_dirty = snp_hit  && (snp_idx == IDX_W'(i));
      upd.set_valid = cmp_set  && (cmp_idx == IDX_W'(i));
      upd.clr_dirty = sw_clr_d && (sw_idx  == IDX_W'(i));
      upd.clr_valid = sw_clr_v && (sw_idx  == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dirty_q[i] <= 1'b0;
        valid_q[i] <= 1'b0;
      end else begin
        // hardware sets take priority over software clears
        if (upd.set_dirty)      dirty_q[i] <= 1'b1;
        else if (upd.clr_dirty) dirty_q[i] <= 1'b0;

        // a write landing together with a good result makes the copy stale
        if (upd.set_dirty && upd.set_valid) valid_q[i] <= 1'b0;
        else if (upd.set_valid)             valid_q[i] <= 1'b1;
        else if (upd.clr_valid)             valid_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lct_frame_phase.sv
module lct_frame_phase (
  input  logic clk,
  input  logic rst,
  input  logic static_en,
  input  logic sof,
  output logic phase_q
);

  always_ff @(posedge clk) begin
    if (rst || !static_en) phase_q <= 1'b0;
    else if (sof)          phase_q <= ~phase_q;
  end

endmodule

// File: rtl/line_coherency_tracker.sv
module line_coherency_tracker #(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int SHW       = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [SHW-1:0]    pitch_shift,
  input  logic              static_en,
  input  logic              sof,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_line,
  input  logic              cmp_ok,
  input  logic              fq_valid,
  input  logic [IDX_W-1:0]  fq_line,
  input  logic              sw_en,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_line,
  input  logic              sw_clr_dirty,
  input  logic              sw_clr_valid,
  output logic              fr_valid,
  output logic              fr_from_cmp,
  output logic              sw_rd_ack,
  output logic              sw_rd_dirty,
  output logic              sw_rd_valid,
  output logic              static_phase
);

  logic                 snp_hit;
  logic [IDX_W-1:0]     snp_idx;
  logic [NUM_LINES-1:0] dirty_q;
  logic [NUM_LINES-1:0] valid_q;
  logic                 sw_wr;
  logic                 sw_rd;
  logic                 use_cmp;

  assign sw_wr = sw_en && sw_we;
  assign sw_rd = sw_en && !sw_we;

  lct_snoop_map #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .SHW(SHW)
  ) u_map (
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .region_base(region_base),
    .pitch_shift(pitch_shift),
    .hit        (snp_hit),
    .idx        (snp_idx)
  );

  lct_bit_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .snp_hit (snp_hit),
    .snp_idx (snp_idx),
    .cmp_set (cmp_valid && cmp_ok),
    .cmp_idx (cmp_line),
    .sw_clr_d(sw_wr && sw_clr_dirty),
    .sw_clr_v(sw_wr && sw_clr_valid),
    .sw_idx  (sw_line),
    .dirty_q (dirty_q),
    .valid_q (valid_q)
  );

  lct_frame_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .static_en(static_en),
    .sof      (sof),
    .phase_q  (static_phase)
  );

  // static frames look at the valid flag alone
  always_comb begin
    use_cmp = valid_q[fq_line] && (!dirty_q[fq_line] || static_phase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_valid    <= 1'b0;
      fr_from_cmp <= 1'b0;
      sw_rd_ack   <= 1'b0;
      sw_rd_dirty <= 1'b0;
      sw_rd_valid <= 1'b0;
    end else begin
      fr_valid    <= fq_valid;
      fr_from_cmp <= fq_valid && use_cmp;
      sw_rd_ack   <= sw_rd;
      sw_rd_dirty <= sw_rd && dirty_q[sw_line];
      sw_rd_valid <= sw_rd && valid_q[sw_line];
    end
  end

endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 static_en,
  input logic                 sof,
  input logic                 static_phase,
  input logic                 fq_valid,
  input logic [IDX_W-1:0]     fq_line,
  input logic                 fr_valid,
  input logic                 fr_from_cmp,
  input logic                 cmp_valid,
  input logic                 cmp_ok,
  input logic                 sw_en,
  input logic                 sw_we,
  input logic                 sw_clr_dirty,
  input logic [NUM_LINES-1:0] dirty_q,
  input logic [NUM_LINES-1:0] valid_q
);

  // R8
  phase_off_chk: assert property (@(posedge clk) disable iff (rst)
    !static_en |=> !static_phase);

  // R8
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (static_en && sof) |=> (static_phase != $past(static_phase)));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (static_en && !sof) |=> $stable(static_phase));

  // R6
  fetch_ack_chk: assert property (@(posedge clk) disable iff (rst)
    fq_valid |=> fr_valid);

  // R6
  fetch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fq_valid |=> (!fr_valid && !fr_from_cmp));

  // R6
  fetch_src_chk: assert property (@(posedge clk) disable iff (rst)
    fq_valid |=> (fr_from_cmp ==
      ($past(valid_q[fq_line]) && (!$past(dirty_q[fq_line]) || $past(static_phase)))));

  // R9
  dirty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_en && sw_we && sw_clr_dirty) |=> ((dirty_q & $past(dirty_q)) == $past(dirty_q)));

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmp_valid && cmp_ok) |=> ((valid_q & ~$past(valid_q)) == '0));

endmodule

bind line_coherency_tracker lct_checker #(
  .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
) u_lct_chk (
  .clk         (clk),
  .rst         (rst),
  .static_en   (static_en),
  .sof         (sof),
  .static_phase(static_phase),
  .fq_valid    (fq_valid),
  .fq_line     (fq_line),
  .fr_valid    (fr_valid),
  .fr_from_cmp (fr_from_cmp),
  .cmp_valid   (cmp_valid),
  .cmp_ok      (cmp_ok),
  .sw_en       (sw_en),
  .sw_we       (sw_we),
  .sw_clr_dirty(sw_clr_dirty),
  .dirty_q     (dirty_q),
  .valid_q     (valid_q)
);

// File: tb/sim_line_coherency_tracker.sv
module sim_line_coherency_tracker;

  localparam int ADDR_W = 32;
  localparam int NUM_LINES = 64;
  localparam int IDX_W = 6;
  localparam int SHW = 5;
  localparam logic [ADDR_W-1:0] BASE = 32'h0010_0000;
  localparam int PSH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] region_base = BASE;
  logic [SHW-1:0] pitch_shift = SHW'(PSH);
  logic static_en = 0, sof = 0;
  logic snp_valid = 0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic cmp_valid = 0, cmp_ok = 0;
  logic [IDX_W-1:0] cmp_line = '0;
  logic fq_valid = 0;
  logic [IDX_W-1:0] fq_line = '0;
  logic sw_en = 0, sw_we = 0, sw_clr_dirty = 0, sw_clr_valid = 0;
  logic [IDX_W-1:0] sw_line = '0;
  logic fr_valid, fr_from_cmp, sw_rd_ack, sw_rd_dirty, sw_rd_valid, static_phase;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_coherency_tracker #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u0 (
    .clk(clk), .rst(rst), .region_base(region_base), .pitch_shift(pitch_shift),
    .static_en(static_en), .sof(sof), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .cmp_valid(cmp_valid), .cmp_line(cmp_line), .cmp_ok(cmp_ok),
    .fq_valid(fq_valid), .fq_line(fq_line), .sw_en(sw_en), .sw_we(sw_we),
    .sw_line(sw_line), .sw_clr_dirty(sw_clr_dirty), .sw_clr_valid(sw_clr_valid),
    .fr_valid(fr_valid), .fr_from_cmp(fr_from_cmp), .sw_rd_ack(sw_rd_ack),
    .sw_rd_dirty(sw_rd_dirty), .sw_rd_valid(sw_rd_valid), .static_phase(static_phase)
  );

  // vector: op[2:0] line[5:0] req[3:0] exp[1:0]
  localparam logic [2:0] OP_SNP = 0, OP_OK = 1, OP_FAIL = 2, OP_CLRD = 3,
                         OP_FETCH = 4, OP_READ = 5, OP_CLRV = 6;
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {OP_READ,  6'd3,  4'd1,  2'b00},
    {OP_OK,    6'd3,  4'd4,  2'b00},
    {OP_READ,  6'd3,  4'd4,  2'b01},
    {OP_FETCH, 6'd3,  4'd6,  2'b01},
    {OP_SNP,   6'd3,  4'd2,  2'b00},
    {OP_READ,  6'd3,  4'd2,  2'b11},
    {OP_FETCH, 6'd3,  4'd6,  2'b00},
    {OP_FAIL,  6'd5,  4'd4,  2'b00},
    {OP_READ,  6'd5,  4'd4,  2'b00},
    {OP_OK,    6'd63, 4'd4,  2'b00},
    {OP_FETCH, 6'd63, 4'd6,  2'b01},
    {OP_SNP,   6'd0,  4'd2,  2'b00},
    {OP_READ,  6'd0,  4'd10, 2'b10},
    {OP_CLRD,  6'd3,  4'd9,  2'b00},
    {OP_READ,  6'd3,  4'd9,  2'b01},
    {OP_FETCH, 6'd3,  4'd6,  2'b01},
    {OP_CLRV,  6'd3,  4'd9,  2'b00},
    {OP_READ,  6'd3,  4'd9,  2'b00},
    {OP_FETCH, 6'd0,  4'd6,  2'b00}
  };

  function automatic string rq(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string r, input string what, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", r, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    snp_valid = 0; cmp_valid = 0; cmp_ok = 0; fq_valid = 0;
    sw_en = 0; sw_we = 0; sw_clr_dirty = 0; sw_clr_valid = 0; sof = 0;
  endtask

  function automatic logic [ADDR_W-1:0] la(input int line);
    return BASE + (ADDR_W'(line) << PSH);
  endfunction

  task automatic snoop(input logic [ADDR_W-1:0] a);
    snp_valid = 1; snp_addr = a; tick(); clear_in();
  endtask

  task automatic cres(input int line, input logic ok);
    cmp_valid = 1; cmp_ok = ok; cmp_line = IDX_W'(line); tick(); clear_in();
  endtask

  task automatic swclr(input int line, input logic d, input logic v);
    sw_en = 1; sw_we = 1; sw_line = IDX_W'(line); sw_clr_dirty = d; sw_clr_valid = v;
    tick(); clear_in();
  endtask

  task automatic rd(input int line, input string r, input logic [1:0] exp);
    sw_en = 1; sw_we = 0; sw_line = IDX_W'(line); tick(); clear_in();
    chk(r, "read ack", {3'b0, sw_rd_ack}, 4'd1);
    chk(r, $sformatf("read line %0d {dirty,valid}", line), {2'b0, sw_rd_dirty, sw_rd_valid}, {2'b0, exp});
  endtask

  task automatic fetch(input int line, input string r, input logic exp);
    fq_valid = 1; fq_line = IDX_W'(line); tick(); clear_in();
    chk(r, $sformatf("fetch line %0d source", line), {2'b0, fr_valid, fr_from_cmp}, {2'b0, 1'b1, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    // R1: reset state at the ports
    chk("R1", "static_phase after reset", {3'b0, static_phase}, 4'd0);
    chk("R1", "outputs after reset", {fr_valid, fr_from_cmp, sw_rd_ack, sw_rd_dirty}, 4'd0);
    rd(40, "R1", 2'b00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      int ln;
      string r;
      op = VEC[i][14:12];
      ln = int'(VEC[i][11:6]);
      r  = rq(int'(VEC[i][5:2]));
      case (op)
        OP_SNP:   snoop(la(ln));
        OP_OK:    cres(ln, 1'b1);
        OP_FAIL:  cres(ln, 1'b0);
        OP_CLRD:  swclr(ln, 1'b1, 1'b0);
        OP_CLRV:  swclr(ln, 1'b0, 1'b1);
        OP_FETCH: fetch(ln, r, VEC[i][0]);
        OP_READ:  rd(ln, r, VEC[i][1:0]);
        default:  ;
      endcase
    end

    // R3: out-of-region and non-valid writes
    swclr(0, 1'b1, 1'b0);
    snoop(BASE + (ADDR_W'(NUM_LINES) << PSH));
    rd(0, "R3", 2'b00);
    snoop(BASE - 32'd4);
    rd(63, "R3", 2'b01);
    snp_addr = la(7); tick();
    rd(7, "R3", 2'b00);
    // R2: address mid-line maps to its line
    snoop(la(9) + 32'd200);
    rd(9, "R2", 2'b10);
    rd(10, "R2", 2'b00);

    // R5: same-line collision, and different lines together
    cres(10, 1'b1);
    snp_valid = 1; snp_addr = la(10); cmp_valid = 1; cmp_ok = 1; cmp_line = 10; tick(); clear_in();
    rd(10, "R5", 2'b10);
    snp_valid = 1; snp_addr = la(11); cmp_valid = 1; cmp_ok = 1; cmp_line = 12; tick(); clear_in();
    rd(11, "R5", 2'b10);
    rd(12, "R5", 2'b01);

    // R11: hardware set beats software clear
    cmp_valid = 1; cmp_ok = 1; cmp_line = 12;
    sw_en = 1; sw_we = 1; sw_line = 12; sw_clr_valid = 1; tick(); clear_in();
    rd(12, "R11", 2'b01);
    snp_valid = 1; snp_addr = la(13);
    sw_en = 1; sw_we = 1; sw_line = 13; sw_clr_dirty = 1; tick(); clear_in();
    rd(13, "R11", 2'b10);

    // R7 / R8: static frames
    cres(20, 1'b1);
    snoop(la(20));
    snoop(la(21));
    static_en = 1;
    sof = 1; tick(); sof = 0;
    chk("R8", "phase after first sof", {3'b0, static_phase}, 4'd1);
    fetch(20, "R7", 1'b1);
    fetch(21, "R7", 1'b0);
    tick();
    chk("R8", "phase holds without sof", {3'b0, static_phase}, 4'd1);
    sof = 1; tick(); sof = 0;
    chk("R8", "phase after second sof", {3'b0, static_phase}, 4'd0);
    fetch(20, "R6", 1'b0);
    sof = 1; tick(); sof = 0;
    chk("R8", "phase after third sof", {3'b0, static_phase}, 4'd1);
    static_en = 0; tick();
    chk("R8", "phase cleared by disable", {3'b0, static_phase}, 4'd0);
    sof = 1; tick(); sof = 0;
    chk("R8", "sof ignored while disabled", {3'b0, static_phase}, 4'd0);
    fetch(20, "R6", 1'b0);
    rd(20, "R9", 2'b11);

    finish_run();
  end

endmodule